// File: doc/BRIEF.md
# Clock-Stop Handshake Sequencer

This block sequences entry into and exit from a low-power clock-stop state for a serial bus controller. Software raises a stop request bit. The sequencer then waits until the transmit side reports that nothing is queued. After that it waits for the bus to fall quiet. It then forces the controller's init bit high, which halts further bus traffic. One cycle later it raises an acknowledge that tells software the clocks may be stopped.

To leave the state, software turns the clocks back on and clears the request. The acknowledge drops one cycle later. The init bit stays high until software clears it, and that clear restarts traffic. If software drops the request before the acknowledge is reached, the sequencer goes back to rest and leaves init untouched. The pending and idle flags come from the protocol engine. Clock gating itself happens outside this block.

Top module: `clkstop_hs_ctrl`

## Requirements
- R1: After reset, stop_req_o and stop_ack_o are 0 and init_o equals the parameter INIT_RST_VAL (default 1).
- R2: A write on the stop request port (stop_req_wr_i high) loads stop_req_wdata_i. The value is visible on stop_req_o after the next rising edge and holds until the next write.
- R3: While tx_pending_i stays high, a held request never raises stop_ack_o and the sequencer does not force init_o.
- R4: After tx_pending_i falls, the sequencer does not raise stop_ack_o or force init_o while bus_idle_i stays low.
- R5: On a rising edge where the sequencer is waiting for bus idle with bus_idle_i high and the request still set, init_o becomes 1. stop_ack_o becomes 1 exactly one edge later, never in the same edge. With tx_pending_i low and bus_idle_i high throughout, init_o rises on the third edge after the request write edge and stop_ack_o on the fourth.
- R6: From the edge that forces init until the sequencer leaves the acknowledged state, a software write of 0 to init leaves init_o at 1.
- R7: When stop_req_o goes low while stop_ack_o is high, stop_ack_o falls on the next edge and init_o stays 1.
- R8: If the request is cleared before stop_ack_o is reached, the sequencer returns to rest without raising stop_ack_o or changing init_o. A later idle bus does not force init_o.
- R9: Outside the forced and acknowledged phases, an init write (init_wr_i high) loads init_wdata_i into init_o on the next edge.
- R10: After the acknowledge has dropped, software can clear init_o with an ordinary write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| stop_req_wr_i | input | 1 | Write strobe for the stop request bit |
| stop_req_wdata_i | input | 1 | Value written to the stop request bit |
| init_wr_i | input | 1 | Write strobe for the init bit |
| init_wdata_i | input | 1 | Value written to the init bit |
| tx_pending_i | input | 1 | High while transmissions remain queued |
| bus_idle_i | input | 1 | High while the bus is idle |
| stop_req_o | output | 1 | Read-back of the stop request bit |
| init_o | output | 1 | Init bit; high halts bus traffic |
| stop_ack_o | output | 1 | High when the block is ready for clock stop |

## Verification
Every register write appears on its output after one edge. On the fastest path, the forced init arrives on the third edge after the request write and the acknowledge on the fourth. The acknowledge drops one edge after the request read-back goes low. The bench drives inputs and samples outputs on the falling edge. It advances a counted number of edges from each stimulus before sampling, so each check lands on the exact edge its requirement names. It also takes one sample an edge early, which shows that init and acknowledge never rise together.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

    typedef enum logic [2:0] {
        CS_IDLE     = 3'd0,
        CS_WAIT_TX  = 3'd1,
        CS_WAIT_BUS = 3'd2,
        CS_SET_INIT = 3'd3,
        CS_ACKED    = 3'd4
    } cs_state_e;

    typedef struct packed {
        cs_state_e st;
        logic      ack;
    } seq_regs_t;

    typedef struct packed {
        logic val;
    } bit_reg_t;

endpackage

// File: rtl/clkstop_bit_reg.sv
module clkstop_bit_reg #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic wr_i,
    input  logic wdata_i,
    input  logic force_i,
    input  logic lock_i,
    output logic q_o
);
    import clkstop_pkg::*;

    bit_reg_t r_d, r_q;

    // Forcing wins; a locked register ignores software writes.
    always_comb begin
        r_d = r_q;
        if (force_i) begin
            r_d.val = 1'b1;
        end else if (wr_i && !lock_i) begin
            r_d.val = wdata_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q.val <= RST_VAL;
        end else begin
            r_q <= r_d;
        end
    end

    assign q_o = r_q.val;
endmodule

// File: rtl/clkstop_seq.sv
module clkstop_seq (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic req_i,
    input  logic tx_pending_i,
    input  logic bus_idle_i,
    output logic force_init_o,
    output logic lock_init_o,
    output logic ack_o
);
    import clkstop_pkg::*;

    seq_regs_t s_d, s_q;
    logic      force_now;

    always_comb begin
        s_d       = s_q;
        force_now = 1'b0;
        unique case (s_q.st)
            CS_IDLE: begin
                if (req_i) s_d.st = CS_WAIT_TX;
            end
            CS_WAIT_TX: begin
                if (!req_i)            s_d.st = CS_IDLE;
                else if (!tx_pending_i) s_d.st = CS_WAIT_BUS;
            end
            CS_WAIT_BUS: begin
                if (!req_i) begin
                    s_d.st = CS_IDLE;
                end else if (bus_idle_i) begin
                    s_d.st    = CS_SET_INIT;
                    force_now = 1'b1;
                end
            end
            CS_SET_INIT: begin
                s_d.st = CS_ACKED;
            end
            CS_ACKED: begin
                if (!req_i) s_d.st = CS_IDLE;
            end
            default: begin
                s_d.st = CS_IDLE;
            end
        endcase
        s_d.ack = (s_d.st == CS_ACKED);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q.st  <= CS_IDLE;
            s_q.ack <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign force_init_o = force_now;
    assign lock_init_o  = (s_q.st == CS_SET_INIT) || (s_q.st == CS_ACKED);
    assign ack_o        = s_q.ack;
endmodule

// File: rtl/clkstop_hs_ctrl.sv
module clkstop_hs_ctrl #(
    parameter logic INIT_RST_VAL = 1'b1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic stop_req_wr_i,
    input  logic stop_req_wdata_i,
    input  logic init_wr_i,
    input  logic init_wdata_i,
    input  logic tx_pending_i,
    input  logic bus_idle_i,
    output logic stop_req_o,
    output logic init_o,
    output logic stop_ack_o
);
    logic req_q;
    logic force_init;
    logic lock_init;

    clkstop_bit_reg #(.RST_VAL(1'b0)) u_req (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_i    (stop_req_wr_i),
        .wdata_i (stop_req_wdata_i),
        .force_i (1'b0),
        .lock_i  (1'b0),
        .q_o     (req_q)
    );

    clkstop_seq u_seq (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .req_i        (req_q),
        .tx_pending_i (tx_pending_i),
        .bus_idle_i   (bus_idle_i),
        .force_init_o (force_init),
        .lock_init_o  (lock_init),
        .ack_o        (stop_ack_o)
    );

    clkstop_bit_reg #(.RST_VAL(INIT_RST_VAL)) u_init (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_i    (init_wr_i),
        .wdata_i (init_wdata_i),
        .force_i (force_init),
        .lock_i  (lock_init),
        .q_o     (init_o)
    );

    assign stop_req_o = req_q;
endmodule

// File: rtl/clkstop_hs_chk.sv
module clkstop_hs_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic stop_req_wr_i,
    input logic stop_req_wdata_i,
    input logic init_wr_i,
    input logic init_wdata_i,
    input logic tx_pending_i,
    input logic bus_idle_i,
    input logic stop_req_o,
    input logic init_o,
    input logic stop_ack_o
);
    // R2
    req_readback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stop_req_wr_i |=> (stop_req_o == $past(stop_req_wdata_i)));

    // R5
    ack_needs_init_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stop_ack_o |-> init_o);

    // R5
    init_before_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(stop_ack_o) |-> ($past(init_o) && stop_req_o));

    // R4
    ack_after_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(stop_ack_o) |-> $past(bus_idle_i, 2));

    // R6
    init_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stop_ack_o && stop_req_o && init_wr_i) |=> init_o);

    // R7
    ack_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stop_ack_o && !stop_req_o) |=> (!stop_ack_o && init_o));

    // R9
    init_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (init_wr_i && !stop_req_o && !stop_ack_o) |=> (init_o == $past(init_wdata_i)));

    // R3
    pending_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tx_pending_i && !stop_ack_o) |=> !stop_ack_o);
endmodule

bind clkstop_hs_ctrl clkstop_hs_chk u_chk (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .stop_req_wr_i    (stop_req_wr_i),
    .stop_req_wdata_i (stop_req_wdata_i),
    .init_wr_i        (init_wr_i),
    .init_wdata_i     (init_wdata_i),
    .tx_pending_i     (tx_pending_i),
    .bus_idle_i       (bus_idle_i),
    .stop_req_o       (stop_req_o),
    .init_o           (init_o),
    .stop_ack_o       (stop_ack_o)
);

// File: tb/sim_clkstop_hs_ctrl.sv
`timescale 1ns/1ps
module sim_clkstop_hs_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_wr = 1'b0, req_wd = 1'b0, ini_wr = 1'b0, ini_wd = 1'b0;
    logic pend = 1'b0, idle = 1'b0;
    logic req_o, init_o, ack_o;
    int   checks = 0, errors = 0;
    bit   done = 1'b0;

    always #4 clk = ~clk;

    clkstop_hs_ctrl u0 (
        .clk_i(clk), .rst_ni(rst_n),
        .stop_req_wr_i(req_wr), .stop_req_wdata_i(req_wd),
        .init_wr_i(ini_wr), .init_wdata_i(ini_wd),
        .tx_pending_i(pend), .bus_idle_i(idle),
        .stop_req_o(req_o), .init_o(init_o), .stop_ack_o(ack_o)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%b exp=%b t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic wr_req(input logic v);
        req_wr = 1'b1; req_wd = v; step(1); req_wr = 1'b0;
    endtask

    task automatic wr_init(input logic v);
        ini_wr = 1'b1; ini_wd = v; step(1); ini_wr = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 stop_req_o", req_o, 1'b0);
        chk("R1 stop_ack_o", ack_o, 1'b0);
        chk("R1 init_o", init_o, 1'b1);
    endtask

    task automatic t_sw_init;
        wr_init(1'b0);
        chk("R9 init cleared", init_o, 1'b0);
        wr_init(1'b1);
        chk("R9 init set", init_o, 1'b1);
        wr_init(1'b0);
        chk("R9 init cleared again", init_o, 1'b0);
    endtask

    task automatic t_slow_entry;
        pend = 1'b1; idle = 1'b0;
        wr_req(1'b1);
        chk("R2 req readback", req_o, 1'b1);
        step(6);
        chk("R3 no ack while pending", ack_o, 1'b0);
        chk("R3 init not forced", init_o, 1'b0);
        pend = 1'b0;
        step(4);
        chk("R4 no ack while bus busy", ack_o, 1'b0);
        chk("R4 init not forced", init_o, 1'b0);
        idle = 1'b1;
        step(1);
        chk("R5 init forced", init_o, 1'b1);
        chk("R5 ack not yet", ack_o, 1'b0);
        step(1);
        chk("R5 ack raised", ack_o, 1'b1);
        wr_init(1'b0);
        chk("R6 init write ignored", init_o, 1'b1);
        chk("R6 ack held", ack_o, 1'b1);
        wr_req(1'b0);
        chk("R2 req cleared", req_o, 1'b0);
        chk("R7 ack still high on clear edge", ack_o, 1'b1);
        step(1);
        chk("R7 ack dropped", ack_o, 1'b0);
        chk("R7 init kept", init_o, 1'b1);
        wr_init(1'b0);
        chk("R10 init cleared after exit", init_o, 1'b0);
    endtask

    task automatic t_fast_entry;
        pend = 1'b0; idle = 1'b1;
        wr_req(1'b1);
        step(2);
        chk("R5 init low before edge 3", init_o, 1'b0);
        step(1);
        chk("R5 init at edge 3", init_o, 1'b1);
        chk("R5 no ack at edge 3", ack_o, 1'b0);
        step(1);
        chk("R5 ack at edge 4", ack_o, 1'b1);
        wr_req(1'b0);
        step(1);
        chk("R7 ack dropped", ack_o, 1'b0);
        wr_init(1'b0);
        chk("R10 init cleared", init_o, 1'b0);
    endtask

    task automatic t_abort_pending;
        pend = 1'b1; idle = 1'b1;
        wr_req(1'b1);
        step(3);
        wr_req(1'b0);
        step(2);
        chk("R8 no ack after abort", ack_o, 1'b0);
        chk("R8 init untouched", init_o, 1'b0);
        pend = 1'b0;
        step(6);
        chk("R8 no later forcing", init_o, 1'b0);
        chk("R8 no later ack", ack_o, 1'b0);
    endtask

    task automatic t_abort_bus;
        pend = 1'b0; idle = 1'b0;
        wr_req(1'b1);
        step(4);
        wr_req(1'b0);
        step(1);
        idle = 1'b1;
        step(5);
        chk("R8 bus-wait abort init", init_o, 1'b0);
        chk("R8 bus-wait abort ack", ack_o, 1'b0);
    endtask

    initial begin
        step(2);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_sw_init();
        t_slow_entry();
        t_fast_entry();
        t_abort_pending();
        t_abort_bus();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL all watchdog act=running exp=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule